// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block generates the column address stream for one burst access inside an open SDRAM page. A controller first programs a small mode register with four fields: the burst length, the wrap order (sequential or interleaved), the read latency (2 or 3 clocks) and a write policy that can limit every write to one beat. The controller then issues a start strobe that carries a start column and a read/write flag. From the next cycle on, the block presents one column per clock together with a beat strobe. It raises a one-cycle completion pulse after the final beat.

A start strobe is honoured on every cycle, including in the middle of a running burst. This lets a controller issue a fresh random column on every clock. Full-page bursts step through all 256 columns, wrap from the top column back to zero, and keep running until a terminate input ends them. Alongside the addresses, the block produces two data-beat strobes. The read strobe is delayed by the programmed latency. The write strobe lines up with the address.

The sequencer is a three-state machine. ST_IDLE means no beat is being presented. ST_BURST means a fixed-length burst is running. ST_PAGE means a full-page burst is running.

The transitions are:

- start (any state) goes to ST_BURST, or to ST_PAGE if the effective length is full page.
- stop (ST_BURST or ST_PAGE) goes to ST_IDLE with a completion pulse.
- last-beat (ST_BURST with the beat counter at length-1) goes to ST_IDLE with a completion pulse.
- advance (ST_BURST or ST_PAGE) stays in the same state and steps the beat counter.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset no beat, completion pulse or data-valid strobe is present. The mode register holds length code 0 (one beat), sequential order, latency 2 and write bursts enabled.
- R2: The mode register loads on a clock edge where `mode_load` is high and no burst is running. A load requested while a burst is running is ignored. A start on the same edge as a load uses the previous mode.
- R3: Length code 0, 1, 2 or 3 gives 1, 2, 4 or 8 beats. Code 7 gives a full-page burst. Codes 4, 5 and 6 give a single beat.
- R4: In the cycle after the edge that samples `cmd_start`, `col_valid` is high and `col_out` equals `cmd_col`. `col_valid` stays high for each beat of the burst.
- R5: With `mode_ilv` = 0 and length L, beat k carries the start column with its low log2(L) bits replaced by (start low bits + k) mod L. The upper bits are unchanged.
- R6: With `mode_ilv` = 1 and length L, beat k carries the start column with its low log2(L) bits XORed with k.
- R7: A full-page burst always steps sequentially: column (start + k) mod 256, wrapping from 255 to 0. It runs until `cmd_stop` is sampled, and no beat appears in the cycle after that edge.
- R8: `cmd_start` takes priority over `cmd_stop` and over burst completion. It restarts from the new column at once, and an interrupted burst produces no completion pulse.
- R9: `burst_done` is high for exactly one cycle: the cycle after the last beat of a burst, or the cycle after a stop ends a burst.
- R10: With `mode_wr_single` = 1 a write burst has one beat whatever its length code, while read bursts keep the programmed length.
- R11: `rd_data_valid` follows each read beat by one cycle at latency 2 (`mode_cl3` = 0) and by two cycles at latency 3. `wr_data_valid` is high in the same cycle as each write beat.
- R12: `cmd_stop` sampled while no burst runs has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Load request for the mode register |
| mode_len | input | 3 | Burst length code (0..3: 1/2/4/8, 7: full page, others: 1) |
| mode_ilv | input | 1 | 1 = interleaved wrap order, 0 = sequential |
| mode_cl3 | input | 1 | 1 = read latency 3, 0 = read latency 2 |
| mode_wr_single | input | 1 | 1 = every write is a single beat |
| cmd_start | input | 1 | Start a burst at `cmd_col` |
| cmd_write | input | 1 | Direction of the started burst, 1 = write |
| cmd_col | input | 8 | Start column |
| cmd_stop | input | 1 | Terminate the running burst |
| col_out | output | 8 | Column of the current beat |
| col_valid | output | 1 | A beat is presented this cycle |
| burst_done | output | 1 | One-cycle completion pulse |
| rd_data_valid | output | 1 | Read data beat due this cycle |
| wr_data_valid | output | 1 | Write data beat due this cycle |

## Verification
A start sampled at edge N produces beat 0 in the cycle after N. Each further beat follows one cycle later. The completion pulse comes one cycle after the last beat. The read strobe trails its address by latency-1 cycles, and the write strobe shares the address cycle. A behavioural model in the bench advances on every rising edge from the same sampled inputs, with a small history of read beats standing in for the latency. The DUT outputs are compared against it on every falling edge, so each result is checked in exactly the cycle it is due. Extra scenario checks count beats and completion pulses for mode loads, restarts, stops, wrapping and the single-write policy.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } beat_state_e;

    typedef struct packed {
        logic [2:0] len_code;
        logic       ilv;
        logic       cl3;
        logic       wr_single;
    } burst_mode_t;

    localparam logic [2:0] LEN_CODE_PAGE    = 3'd7;
    localparam logic [2:0] LEN_CODE_MAX_POW = 3'd3;

endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
    import colgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic        busy,
    input  burst_mode_t mode_in,
    output burst_mode_t mode_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (load && !busy) begin
            mode_q <= mode_in;
        end
    end

    // Settings must not move while a burst is running
    assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode_q));

endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  burst_mode_t      mode,
    input  logic             start,
    input  logic             write,
    input  logic [COL_W-1:0] col_in,
    input  logic             stop,
    output logic [COL_W-1:0] col_o,
    output logic             col_valid,
    output logic             wr_beat,
    output logic             rd_beat,
    output logic             done,
    output logic             busy
);

    beat_state_e      state_q;
    logic [COL_W-1:0] st_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] mask_q;
    logic             ilv_q;
    logic             wr_q;
    logic             done_q;

    logic [COL_W-1:0] nxt_mask;
    logic             nxt_page;

    // Effective length of a burst started now
    always_comb begin
        nxt_mask = '0;
        nxt_page = 1'b0;
        if (mode.len_code == LEN_CODE_PAGE) begin
            nxt_page = 1'b1;
        end else if (mode.len_code <= LEN_CODE_MAX_POW) begin
            nxt_mask = (COL_W'(1) << mode.len_code) - COL_W'(1);
        end
        if (write && mode.wr_single) begin
            nxt_mask = '0;
            nxt_page = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            st_q    <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                state_q <= nxt_page ? ST_PAGE : ST_BURST;
                st_q    <= col_in;
                beat_q  <= '0;
                mask_q  <= nxt_mask;
                ilv_q   <= mode.ilv;
                wr_q    <= write;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                    end
                    ST_BURST: begin
                        if (stop || (beat_q == mask_q)) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            beat_q <= beat_q + COL_W'(1);
                        end
                    end
                    ST_PAGE: begin
                        if (stop) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            beat_q <= beat_q + COL_W'(1);
                        end
                    end
                    default: begin
                        state_q <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        col_valid = busy;
        wr_beat   = busy && wr_q;
        rd_beat   = busy && !wr_q;
        done      = done_q;
        unique case (state_q)
            ST_PAGE:  col_o = st_q + beat_q;
            ST_BURST: col_o = ilv_q
                ? ((st_q & ~mask_q) | ((st_q ^ beat_q) & mask_q))
                : ((st_q & ~mask_q) | ((st_q + beat_q) & mask_q));
            default:  col_o = '0;
        endcase
    end

    assert_first_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start && rst_n) |-> (col_valid && (col_o == $past(col_in))));

    assert_page_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_PAGE) && $past(state_q == ST_PAGE) && !$past(start))
            |-> (col_o == COL_W'($past(col_o) + COL_W'(1))));

    assert_done_after_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/colgen_lat_pipe.sv
module colgen_lat_pipe #(
    parameter int MAX_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_rd,
    input  logic lat_hi,
    output logic rd_valid
);

    localparam int DEPTH = MAX_LAT - 1;

    logic [DEPTH-1:0] sh_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q[i] <= 1'b0;
            end else if (i == 0) begin
                sh_q[i] <= beat_rd;
            end else begin
                sh_q[i] <= sh_q[(i == 0) ? 0 : i - 1];
            end
        end
    end

    assign rd_valid = lat_hi ? sh_q[DEPTH-1] : sh_q[DEPTH-2];

    // The read strobe never appears without a read beat in the window before it
    assert_rd_has_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(beat_rd) || $past(beat_rd, 2)));

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W   = 8,
    parameter int MAX_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_load,
    input  logic [2:0]       mode_len,
    input  logic             mode_ilv,
    input  logic             mode_cl3,
    input  logic             mode_wr_single,
    input  logic             cmd_start,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_stop,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             burst_done,
    output logic             rd_data_valid,
    output logic             wr_data_valid
);

    burst_mode_t mode_in;
    burst_mode_t mode_q;
    logic        busy;
    logic        rd_beat;
    logic        wr_beat;

    assign mode_in = '{len_code: mode_len, ilv: mode_ilv, cl3: mode_cl3, wr_single: mode_wr_single};

    colgen_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (mode_load),
        .busy    (busy),
        .mode_in (mode_in),
        .mode_q  (mode_q)
    );

    colgen_seq #(.COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .start     (cmd_start),
        .write     (cmd_write),
        .col_in    (cmd_col),
        .stop      (cmd_stop),
        .col_o     (col_out),
        .col_valid (col_valid),
        .wr_beat   (wr_beat),
        .rd_beat   (rd_beat),
        .done      (burst_done),
        .busy      (busy)
    );

    colgen_lat_pipe #(.MAX_LAT(MAX_LAT)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat_rd  (rd_beat),
        .lat_hi   (mode_q.cl3),
        .rd_valid (rd_data_valid)
    );

    assign wr_data_valid = wr_beat;

endmodule

// File: tb/sdram_burst_colgen_bench.sv
module sdram_burst_colgen_bench;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_load = 1'b0;
    logic [2:0] mode_len = 3'd0;
    logic       mode_ilv = 1'b0;
    logic       mode_cl3 = 1'b0;
    logic       mode_wr_single = 1'b0;
    logic       cmd_start = 1'b0;
    logic       cmd_write = 1'b0;
    logic [7:0] cmd_col = 8'd0;
    logic       cmd_stop = 1'b0;
    logic [7:0] col_out;
    logic       col_valid;
    logic       burst_done;
    logic       rd_data_valid;
    logic       wr_data_valid;

    int total = 0;
    int bad = 0;
    int nbeats = 0;
    int ndone = 0;
    bit run_chk = 0;

    always #(PERIOD/2) clk = ~clk;

    sdram_burst_colgen u_sdram_burst_colgen (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_len(mode_len),
        .mode_ilv(mode_ilv), .mode_cl3(mode_cl3), .mode_wr_single(mode_wr_single),
        .cmd_start(cmd_start), .cmd_write(cmd_write), .cmd_col(cmd_col),
        .cmd_stop(cmd_stop), .col_out(col_out), .col_valid(col_valid),
        .burst_done(burst_done), .rd_data_valid(rd_data_valid),
        .wr_data_valid(wr_data_valid)
    );

    // Reference model state
    int m_len = 0, m_ilv = 0, m_cl3 = 0, m_ws = 0;
    int e_act = 0, e_page = 0, e_beat = 0, e_len = 1, e_start = 0;
    int e_ilv = 0, e_wr = 0, e_done = 0, e_rdh1 = 0, e_rdh2 = 0;

    function automatic int len_of(input int code);
        if (code <= 3) return 1 << code;
        if (code == 7) return 256;
        return 1;
    endfunction

    function automatic int exp_col();
        int base, off;
        if (e_page) return (e_start + e_beat) % 256;
        off  = e_start % e_len;
        base = e_start - off;
        if (e_ilv) return base + (off ^ e_beat);
        return base + ((off + e_beat) % e_len);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_len = 0; m_ilv = 0; m_cl3 = 0; m_ws = 0;
            e_act = 0; e_page = 0; e_beat = 0; e_len = 1; e_start = 0;
            e_ilv = 0; e_wr = 0; e_done = 0; e_rdh1 = 0; e_rdh2 = 0;
        end else begin
            int was_act;
            int len;
            was_act = e_act;
            e_rdh2 = e_rdh1;
            e_rdh1 = (e_act && !e_wr) ? 1 : 0;
            e_done = 0;
            if (cmd_start) begin
                len = len_of(m_len);
                if (cmd_write && m_ws != 0) len = 1;
                e_act = 1; e_page = (len == 256); e_len = len; e_beat = 0;
                e_start = cmd_col; e_ilv = m_ilv; e_wr = cmd_write;
            end else if (e_act && cmd_stop) begin
                e_act = 0; e_done = 1;
            end else if (e_act && !e_page) begin
                if (e_beat == e_len - 1) begin
                    e_act = 0; e_done = 1;
                end else begin
                    e_beat = e_beat + 1;
                end
            end else if (e_act) begin
                e_beat = (e_beat + 1) % 256;
            end
            if (mode_load && !was_act) begin
                m_len = mode_len; m_ilv = mode_ilv; m_cl3 = mode_cl3; m_ws = mode_wr_single;
            end
        end
    end

    task automatic chk(input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && run_chk) begin
            chk(col_valid, e_act, "R4 beat valid");
            if (e_act != 0)
                chk(col_out, exp_col(),
                    e_page != 0 ? "R7 page column" : (e_ilv != 0 ? "R6 interleaved column" : "R5 sequential column"));
            chk(burst_done, e_done, "R9 completion pulse");
            chk(rd_data_valid, m_cl3 != 0 ? e_rdh2 : e_rdh1, "R11 read strobe");
            chk(wr_data_valid, (e_act != 0 && e_wr != 0) ? 1 : 0, "R11 write strobe");
            if (col_valid) nbeats++;
            if (burst_done) ndone++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic load_mode(input int len, input int ilv, input int cl3, input int ws);
        mode_load = 1'b1; mode_len = 3'(len); mode_ilv = 1'(ilv);
        mode_cl3 = 1'(cl3); mode_wr_single = 1'(ws);
        step(1);
        mode_load = 1'b0;
    endtask

    task automatic go(input int col, input int wr);
        cmd_start = 1'b1; cmd_col = 8'(col); cmd_write = 1'(wr);
        step(1);
        cmd_start = 1'b0;
    endtask

    initial begin
        int b0, d0;
        step(3);
        chk(col_valid, 0, "R1 reset beat");
        chk(burst_done, 0, "R1 reset done");
        chk(rd_data_valid, 0, "R1 reset read strobe");
        chk(wr_data_valid, 0, "R1 reset write strobe");
        rst_n = 1'b1;
        run_chk = 1;
        step(1);

        // R1: defaults give a single-beat read at latency 2
        b0 = nbeats; go(8'h35, 0); step(4);
        chk(nbeats - b0, 1, "R1 default length");

        // R12: stop while idle
        cmd_stop = 1'b1; step(1); cmd_stop = 1'b0; step(1);
        chk(col_valid, 0, "R12 stop idle beat");
        chk(burst_done, 0, "R12 stop idle done");

        // R5 with latency 3, length 4
        load_mode(2, 0, 1, 0);
        b0 = nbeats; go(8'h46, 0); step(8);
        chk(nbeats - b0, 4, "R3 length four");

        // R6 interleaved length 8
        load_mode(3, 1, 0, 0);
        b0 = nbeats; go(8'h2D, 0); step(12);
        chk(nbeats - b0, 8, "R3 length eight");

        // R5 sequential length 8, write
        load_mode(3, 0, 0, 0);
        go(8'h2D, 1); step(12);

        // R2: a load during a burst is ignored
        load_mode(2, 0, 0, 0);
        go(8'h10, 0); step(1);
        load_mode(0, 0, 1, 0);
        step(6);
        b0 = nbeats; go(8'h13, 0); step(8);
        chk(nbeats - b0, 4, "R2 load ignored while busy");

        // R3 reserved code
        load_mode(5, 0, 0, 0);
        b0 = nbeats; go(8'h77, 0); step(5);
        chk(nbeats - b0, 1, "R3 reserved code single beat");

        // R7 full page wrap and stop
        load_mode(7, 1, 0, 0);
        b0 = nbeats; d0 = ndone;
        go(8'hFD, 0); step(9);
        cmd_stop = 1'b1; step(1); cmd_stop = 1'b0; step(4);
        chk(nbeats - b0, 10, "R7 page beats until stop");
        chk(ndone - d0, 1, "R7 stop completion");

        // R8 restart mid-burst and start beating stop
        load_mode(3, 0, 1, 0);
        b0 = nbeats; d0 = ndone;
        go(8'h10, 0); step(2);
        cmd_stop = 1'b1; go(8'h80, 0); cmd_stop = 1'b0; step(12);
        chk(nbeats - b0, 11, "R8 restart beats");
        chk(ndone - d0, 1, "R8 single completion");

        // R8 random reads every cycle
        load_mode(2, 0, 0, 0);
        b0 = nbeats; d0 = ndone;
        go(8'h01, 0); go(8'h52, 0); go(8'hA7, 0); go(8'h3C, 0); go(8'hF9, 0);
        step(8);
        chk(nbeats - b0, 8, "R8 per-cycle starts");
        chk(ndone - d0, 1, "R8 completion after last");

        // R10 single-beat writes
        load_mode(3, 1, 1, 1);
        b0 = nbeats; go(8'h64, 1); step(5);
        chk(nbeats - b0, 1, "R10 write single beat");
        b0 = nbeats; go(8'h64, 0); step(12);
        chk(nbeats - b0, 8, "R10 read keeps length");

        step(3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog R4 actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule